// File: doc/BRIEF.md
# Receive CRC and LRC Residual Checker

This block keeps two running integrity checks over the characters that a smart-card style serial receiver delivers. It holds a 16-bit CRC residual and an 8-bit longitudinal redundancy residual. Each residual has its own enable. Every received byte, marked by a one-cycle strobe, updates each residual whose enable is high. For each check the block raises an OK flag whenever the running residual equals the value that a frame with no errors leaves behind.

Each residual returns to its cleared value in three cases: its own enable is low, the transmit-enable set event pulses, or the end-of-transmission event pulses. A new frame therefore always starts from a known state. This holds when the enable is first raised and when the link turns around between transmit and receive. Character framing, parity and any buffering belong to the receiver that feeds the block.

Top module: `rx_check_residue`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `crc_res` reads `CRC_PRESET` (default 16'hFFFF) and `lrc_res` reads 8'h00.
- R2: When `lrc_en` is high, no clear event is present and `rx_valid` is high, `lrc_res` becomes the old residual XOR `rx_data` on the next cycle. With `rx_valid` low, it keeps its value.
- R3: When `crc_en` is high, no clear event is present and `rx_valid` is high, `crc_res` advances by the 8 data bits, taken bit 0 first. For each bit, the feedback is `crc_res[0]` XOR the data bit. The residual is shifted right by one, and `CRC_POLY_REV` (default 16'h8408, which is 0x1021 bit-reversed) is XORed in when the feedback is 1. From the preset, the ASCII bytes "123456789" give 16'h6F91.
- R4: While an enable is low, its residual holds its cleared value (16'hFFFF for the CRC, 8'h00 for the LRC), and byte strobes have no effect on it.
- R5: A one-cycle pulse on `tx_en_set` returns both residuals to their cleared values on the next cycle. This overrides a byte strobe in the same cycle.
- R6: A one-cycle pulse on `tx_done` returns both residuals to their cleared values on the next cycle. This overrides a byte strobe in the same cycle.
- R7: `lrc_ok` is 1 exactly when `lrc_res` is 8'h00.
- R8: `crc_ok` is 1 exactly when `crc_res` equals `CRC_GOOD` (default 16'hF0B8). A frame followed by its complemented CRC, low byte first, drives `crc_ok` high.
- R9: The two checks are independent. Changing one enable leaves the other residual unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| crc_en | input | 1 | CRC check enable (level) |
| lrc_en | input | 1 | LRC check enable (level) |
| tx_en_set | input | 1 | Pulse: transmitter enable was set |
| tx_done | input | 1 | Pulse: end of a transmission |
| crc_ok | output | 1 | CRC residual equals the good-frame constant |
| lrc_ok | output | 1 | LRC residual is zero |
| crc_res | output | 16 | Current CRC residual |
| lrc_res | output | 8 | Current LRC residual |

## Verification
The hardest state to reach from the ports is `crc_ok` high. Only a single 16-bit value of the residual sets it, and random bytes almost never produce that value. The stimulus first sends a known string and checks the residual against its published value. It then appends the complemented CRC that the bench model computed, low byte first, so the residual lands on the good-frame constant. The LRC zero state is reached the same way, by sending the model's current LRC as the next byte. Clear events are sent in the same cycle as byte strobes to show that a clear overrides an update.

// File: rtl/rx_check_residue.sv
module rx_check_residue #(
  parameter logic [15:0] CRC_POLY_REV = 16'h8408,
  parameter logic [15:0] CRC_PRESET   = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD     = 16'hF0B8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        crc_en,
  input  logic        lrc_en,
  input  logic        tx_en_set,
  input  logic        tx_done,
  output logic        crc_ok,
  output logic        lrc_ok,
  output logic [15:0] crc_res,
  output logic [7:0]  lrc_res
);

  logic        clr;
  logic [15:0] crc_next;

  assign clr = tx_en_set | tx_done;

  always_comb begin
    crc_next = crc_res;
    for (int i = 0; i < 8; i++) begin
      if (crc_next[0] ^ rx_data[i]) crc_next = (crc_next >> 1) ^ CRC_POLY_REV;
      else                          crc_next = crc_next >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !crc_en || clr) crc_res <= CRC_PRESET;
    else if (rx_valid)            crc_res <= crc_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lrc_en || clr) lrc_res <= 8'h00;
    else if (rx_valid)            lrc_res <= lrc_res ^ rx_data;
  end

  assign crc_ok = (crc_res == CRC_GOOD);
  assign lrc_ok = (lrc_res == 8'h00);

endmodule

// File: rtl/rx_check_residue_sva.sv
module rx_check_residue_sva #(
  parameter logic [15:0] CRC_PRESET = 16'hFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        crc_en,
  input logic        lrc_en,
  input logic        tx_en_set,
  input logic        tx_done,
  input logic [15:0] crc_res,
  input logic [7:0]  lrc_res
);

  AST_LRC_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !lrc_en |=> lrc_res == 8'h00); // R4
  AST_CRC_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en |=> crc_res == CRC_PRESET); // R4
  AST_TXEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_set |=> crc_res == CRC_PRESET && lrc_res == 8'h00); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> crc_res == CRC_PRESET && lrc_res == 8'h00); // R6
  AST_LRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lrc_en && rx_valid && !tx_en_set && !tx_done |=> lrc_res == $past(lrc_res ^ rx_data)); // R2
  AST_LRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lrc_en && !rx_valid && !tx_en_set && !tx_done |=> $stable(lrc_res)); // R2
  AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_en && !rx_valid && !tx_en_set && !tx_done |=> $stable(crc_res)); // R3

endmodule

bind rx_check_residue rx_check_residue_sva #(.CRC_PRESET(CRC_PRESET)) u_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .crc_en(crc_en), .lrc_en(lrc_en), .tx_en_set(tx_en_set), .tx_done(tx_done),
  .crc_res(crc_res), .lrc_res(lrc_res)
);

// File: tb/rx_check_residue_test.sv
module rx_check_residue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic crc_en = 1'b0, lrc_en = 1'b0, tx_en_set = 1'b0, tx_done = 1'b0;
  logic crc_ok, lrc_ok;
  logic [15:0] crc_res;
  logic [7:0] lrc_res;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string req = "R1";
  logic [15:0] m_crc = 16'hFFFF;
  logic [7:0]  m_lrc = 8'h00;

  always #10 clk = ~clk;

  rx_check_residue uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .crc_en(crc_en), .lrc_en(lrc_en), .tx_en_set(tx_en_set), .tx_done(tx_done),
    .crc_ok(crc_ok), .lrc_ok(lrc_ok), .crc_res(crc_res), .lrc_res(lrc_res)
  );

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    int v = int'(c);
    for (int k = 0; k < 8; k++) begin
      if (((v ^ (int'(d) >> k)) & 1) != 0) v = (v / 2) ^ 'h8408;
      else v = v / 2;
    end
    return v[15:0];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin m_crc = 16'hFFFF; m_lrc = 8'h00; end
    else begin
      if (!crc_en || tx_en_set || tx_done) m_crc = 16'hFFFF;
      else if (rx_valid) m_crc = crc_byte(m_crc, rx_data);
      if (!lrc_en || tx_en_set || tx_done) m_lrc = 8'h00;
      else if (rx_valid) m_lrc = m_lrc ^ rx_data;
    end
  end

  task automatic chk(input logic ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic compare();
    chk(crc_res === m_crc, {req, " crc_res"}, crc_res, m_crc);
    chk(lrc_res === m_lrc, {req, " lrc_res"}, {8'h0, lrc_res}, {8'h0, m_lrc});
    chk(crc_ok === (m_crc == 16'hF0B8), "R8 crc_ok", {15'h0, crc_ok}, {15'h0, m_crc == 16'hF0B8});
    chk(lrc_ok === (m_lrc == 8'h00), "R7 lrc_ok", {15'h0, lrc_ok}, {15'h0, m_lrc == 8'h00});
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic ts = 1'b0, input logic td = 1'b0);
    @(negedge clk);
    compare();
    rx_valid = v; rx_data = d; tx_en_set = ts; tx_done = td;
  endtask

  initial begin
    logic [15:0] fcs;
    step(1'b0, 8'h00); step(1'b1, 8'hA5);
    req = "R1";
    rst_n = 1'b1;
    step(1'b0, 8'h00);
    chk(crc_res === 16'hFFFF && lrc_res === 8'h00, "R1 cleared after reset", crc_res, 16'hFFFF);
    crc_en = 1'b1; lrc_en = 1'b1; req = "R3";
    for (int i = 0; i < 9; i++) step(1'b1, 8'h31 + 8'(i));
    step(1'b0, 8'h00);
    chk(crc_res === 16'h6F91, "R3 check string", crc_res, 16'h6F91);
    fcs = ~m_crc; req = "R8";
    step(1'b1, fcs[7:0]); step(1'b1, fcs[15:8]); step(1'b0, 8'h00);
    chk(crc_ok === 1'b1, "R8 good frame", {15'h0, crc_ok}, 16'h1);
    req = "R2";
    step(1'b1, 8'h3C); step(1'b0, 8'h00); step(1'b0, 8'h00);
    step(1'b1, m_lrc); step(1'b0, 8'h00);
    chk(lrc_ok === 1'b1, "R7 lrc zero", {15'h0, lrc_ok}, 16'h1);
    req = "R4 R9"; lrc_en = 1'b0;
    step(1'b1, 8'h77); step(1'b1, 8'h12); step(1'b0, 8'h00);
    chk(lrc_res === 8'h00 && crc_res !== 16'hFFFF, "R4 R9 lrc off crc runs", {8'h0, lrc_res}, 16'h0);
    lrc_en = 1'b1; crc_en = 1'b0;
    step(1'b1, 8'h5A); step(1'b1, 8'h01); step(1'b0, 8'h00);
    chk(crc_res === 16'hFFFF && lrc_res === 8'h5B, "R4 R9 crc off lrc runs", crc_res, 16'hFFFF);
    crc_en = 1'b1; req = "R5";
    step(1'b1, 8'h44); step(1'b1, 8'h99, 1'b1); step(1'b0, 8'h00);
    chk(crc_res === 16'hFFFF && lrc_res === 8'h00, "R5 tx enable clears", crc_res, 16'hFFFF);
    req = "R6";
    step(1'b1, 8'hC3); step(1'b1, 8'h18, 1'b0, 1'b1); step(1'b0, 8'h00);
    chk(crc_res === 16'hFFFF && lrc_res === 8'h00, "R6 end of tx clears", crc_res, 16'hFFFF);
    req = "R2 R3 R4 R5 R6 mix";
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) crc_en = ($urandom % 4) != 0;
      if (i % 23 == 0) lrc_en = ($urandom % 4) != 0;
      step(1'($urandom), 8'($urandom), ($urandom % 29) == 0, ($urandom % 31) == 0);
    end
    step(1'b0, 8'h00); step(1'b0, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule